// File: doc/BRIEF.md
# Default-Transition DFA Byte Walker

This block walks one deterministic automaton over a byte stream for payload inspection. The transition table is kept compact. The root state holds a full 256-entry row of next states. Every other state holds at most a few labelled (byte, next state) pairs, one fallback pointer to another state and an accepting flag. At any moment exactly one state is current.

When a byte finds no labelled pair in the current state, the walker does not consume it. It moves along the fallback pointer and tries the same byte again in the new state, making one table access per clock. While such a fallback walk is in progress the input is held off, so a byte that needs several hops costs several cycles. The number of fallback hops per byte is capped. If the cap is exceeded, the walker drops the byte, raises an error pulse and returns to the root.

Software fills the table through a simple write port while the walker is idle. A start-of-packet flag on a byte beat makes the lookup begin from the root.

Top module: `dfa_walker`

## Requirements
- R1: With the root as the lookup state, a byte is always consumed in the cycle it is accepted, with no stall, and the next state is the root row entry indexed by that byte.
- R2: In a non-root state, a byte matching a valid labelled slot is consumed without stall. If several slots match, the lowest-numbered slot supplies the next state.
- R3: A byte that misses in a non-root state is not consumed. The current state moves to that state's fallback pointer and the held byte is retried there. `in_ready` stays low for one cycle per hop taken.
- R4: `accept_o` is high for exactly the one cycle after a byte is consumed, and only if the state it lands in has its accepting flag set. It is never high together with `error_o`.
- R5: If the byte still misses after MAX_HOPS hops (default 8), the byte is dropped. `error_o` pulses for one cycle, the state becomes the root (0) and `in_ready` returns high.
- R6: A byte that hits on the state reached by exactly MAX_HOPS hops is consumed normally, with no error.
- R7: When `sop` is high on an accepted beat, the byte is looked up from the root regardless of the current state.
- R8: A table write is ignored while a fallback walk is in progress, and also in any cycle where `in_valid` is high.
- R9: After reset the state is 0, `in_ready` is 1, and `accept_o` and `error_o` are 0.
- R10: Write encodings use `wr_sel`. 0 writes slot `wr_slot` of state `wr_state` with byte `wr_char` and next `wr_next`, marking it valid. 1 writes the fallback pointer `wr_next` and the accepting flag `wr_accept` of `wr_state`. 2 writes root row entry `wr_char` with `wr_next`. 3 does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Write target select (see R10) |
| wr_state | input | SW | State being written |
| wr_slot | input | SLW | Labelled slot index |
| wr_char | input | 8 | Slot byte or root row index |
| wr_next | input | SW | Next state or fallback pointer |
| wr_accept | input | 1 | Accepting flag value |
| sop | input | 1 | Start of packet, qualifies the byte beat |
| in_valid | input | 1 | Byte offered |
| in_byte | input | 8 | Input byte |
| in_ready | output | 1 | Byte can be taken this cycle |
| accept_o | output | 1 | Consumed byte landed in an accepting state |
| error_o | output | 1 | Fallback chain exceeded the hop cap |
| state_o | output | SW | Current state |

## Verification
A wrong current state or a wrong fallback pointer shows up at `state_o` and `accept_o` in the cycle just after the byte is consumed. A miscounted hop counter shows up as a wrong number of low cycles on `in_ready`, or as an `error_o` pulse that comes early, late or not at all, within MAX_HOPS+1 cycles of the beat. A write that slips through while the walker is busy only shows later, when a byte is sent through the entry it corrupted. The bench therefore sends such a byte right after each blocked write.

// File: rtl/dfa_walker.sv
module dfa_walker #(
  parameter int STATES   = 16,
  parameter int SLOTS    = 4,
  parameter int MAX_HOPS = 8,
  localparam int SW  = $clog2(STATES),
  localparam int SLW = $clog2(SLOTS),
  localparam int HW  = $clog2(MAX_HOPS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [SW-1:0]  wr_state,
  input  logic [SLW-1:0] wr_slot,
  input  logic [7:0]     wr_char,
  input  logic [SW-1:0]  wr_next,
  input  logic           wr_accept,
  input  logic           sop,
  input  logic           in_valid,
  input  logic [7:0]     in_byte,
  output logic           in_ready,
  output logic           accept_o,
  output logic           error_o,
  output logic [SW-1:0]  state_o
);

  logic              slot_v [STATES][SLOTS];
  logic [7:0]        slot_c [STATES][SLOTS];
  logic [SW-1:0]     slot_n [STATES][SLOTS];
  logic [SW-1:0]     dflt   [STATES];
  logic [STATES-1:0] acc;
  logic [SW-1:0]     root_row [256];

  logic          busy;
  logic [7:0]    held;
  logic [HW-1:0] hops;
  logic [SW-1:0] cur;

  wire          go     = busy | in_valid;
  wire [7:0]    look_c = busy ? held : in_byte;
  wire [SW-1:0] look_s = (!busy && sop) ? '0 : cur;
  wire          wr_ok  = wr_en & ~busy & ~in_valid;

  logic          hit;
  logic [SW-1:0] nxt;

  always_comb begin
    hit = 1'b0;
    nxt = root_row[look_c];
    if (look_s == '0) hit = 1'b1;
    else
      for (int s = SLOTS - 1; s >= 0; s--)
        if (slot_v[look_s][s] && slot_c[look_s][s] == look_c) begin
          hit = 1'b1;
          nxt = slot_n[look_s][s];
        end
  end

  wire at_cap  = (hops == HW'(MAX_HOPS));
  wire consume = go & hit;
  wire hop     = go & ~hit & ~at_cap;
  wire fail    = go & ~hit & at_cap;

  assign in_ready = ~busy;
  assign state_o  = cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      for (int i = 0; i < STATES; i++) begin
        dflt[i] <= '0;
        for (int s = 0; s < SLOTS; s++) begin
          slot_v[i][s] <= 1'b0;
          slot_c[i][s] <= '0;
          slot_n[i][s] <= '0;
        end
      end
      for (int c = 0; c < 256; c++) root_row[c] <= '0;
    end else if (wr_ok) begin
      case (wr_sel)
        2'd0: begin
          slot_v[wr_state][wr_slot] <= 1'b1;
          slot_c[wr_state][wr_slot] <= wr_char;
          slot_n[wr_state][wr_slot] <= wr_next;
        end
        2'd1: begin
          dflt[wr_state] <= wr_next;
          acc[wr_state]  <= wr_accept;
        end
        2'd2: root_row[wr_char] <= wr_next;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      held     <= '0;
      hops     <= '0;
      cur      <= '0;
      accept_o <= 1'b0;
      error_o  <= 1'b0;
    end else begin
      accept_o <= 1'b0;
      error_o  <= 1'b0;
      if (!busy && sop) cur <= '0;
      if (consume) begin
        cur      <= nxt;
        busy     <= 1'b0;
        hops     <= '0;
        accept_o <= acc[nxt];
      end else if (hop) begin
        cur  <= dflt[look_s];
        busy <= 1'b1;
        held <= look_c;
        hops <= hops + 1'b1;
      end else if (fail) begin
        cur     <= '0;
        busy    <= 1'b0;
        hops    <= '0;
        error_o <= 1'b1;
      end
    end
  end

  // R3
  held_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(held));
  // R5
  hop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hops <= HW'(MAX_HOPS));
  // R5
  err_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> (state_o == '0) && in_ready);
  // R4
  accept_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_o && error_o));
  // R4
  accept_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> acc[cur]);

endmodule

// File: tb/test_dfa_walker.sv
`timescale 1ns/1ps
module test_dfa_walker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_accept = 0, sop = 0, in_valid = 0;
  logic [1:0] wr_sel = 0, wr_slot = 0;
  logic [3:0] wr_state = 0, wr_next = 0;
  logic [7:0] wr_char = 0, in_byte = 0;
  logic in_ready, accept_o, error_o;
  logic [3:0] state_o;
  int checks = 0, fails = 0, cyc = 0, st;
  bit done = 0;

  always #2.5 clk = ~clk;

  dfa_walker i_dfa_walker (.clk, .rst_n, .wr_en, .wr_sel, .wr_state, .wr_slot,
    .wr_char, .wr_next, .wr_accept, .sop, .in_valid, .in_byte, .in_ready,
    .accept_o, .error_o, .state_o);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  task automatic wr(input [1:0] sel, input [3:0] s, input [1:0] sl,
                    input [7:0] ch, input [3:0] nx, input bit ac);
    wr_en = 1; wr_sel = sel; wr_state = s; wr_slot = sl;
    wr_char = ch; wr_next = nx; wr_accept = ac;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic send(input [7:0] b, input bit s, output int stalls);
    in_valid = 1; in_byte = b; sop = s;
    @(negedge clk);
    in_valid = 0; sop = 0; stalls = 0;
    while (!in_ready) begin stalls++; @(negedge clk); end
  endtask

  task automatic expect_out(input string req, input int stalls, input int es,
                            input int estate, input bit eacc, input bit eerr);
    check(stalls == es, {req, " stalls"}, stalls, es);
    check(state_o == estate, {req, " state"}, state_o, estate);
    check(accept_o == eacc, {req, " accept"}, accept_o, eacc);
    check(error_o == eerr, {req, " error"}, error_o, eerr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check(state_o == 0, "R9 state", state_o, 0);
    check(in_ready == 1, "R9 ready", in_ready, 1);
    check(accept_o == 0 && error_o == 0, "R9 flags", accept_o + error_o, 0);

    // R10 table load
    for (int c = 0; c < 256; c++) wr(2, 0, 0, c[7:0], c[3:0] & 4'd3, 0);
    wr(1, 3, 0, 0, 0, 1);
    wr(0, 1, 0, 8'hAA, 3, 0);
    wr(0, 1, 1, 8'hAA, 2, 0);
    wr(1, 1, 0, 0, 0, 0);
    wr(0, 2, 3, 8'h77, 1, 0);
    wr(1, 2, 0, 0, 4, 0);
    for (int k = 4; k <= 10; k++) wr(1, k[3:0], 0, 0, k[3:0] + 4'd1, 0);
    wr(0, 11, 0, 8'h10, 3, 0);
    wr(1, 11, 0, 0, 12, 0);
    wr(1, 12, 0, 0, 0, 0);
    wr(3, 5, 0, 0, 9, 1);  // R10 sel 3 has no effect

    // R1 R7 exhaustive root sweep
    for (int c = 0; c < 256; c++) begin
      send(c[7:0], 1, st);
      expect_out("R1", st, 0, c & 3, (c & 3) == 3, 0);
    end

    // R7 sop overrides current state
    send(8'h02, 1, st);
    send(8'h10, 1, st);
    expect_out("R7", st, 0, 0, 0, 0);

    // R2 slot priority
    send(8'h01, 1, st);
    send(8'hAA, 0, st);
    expect_out("R2 prio", st, 0, 3, 1, 0);
    @(negedge clk);
    check(accept_o == 0, "R4 pulse", accept_o, 0);
    send(8'h02, 1, st);
    send(8'h77, 0, st);
    expect_out("R2 slot3", st, 0, 1, 0, 0);

    // R3 one hop to root, then retry
    send(8'h55, 0, st);
    expect_out("R3 hop", st, 1, 1, 0, 0);
    send(8'h57, 0, st);
    expect_out("R3 hop acc", st, 1, 3, 1, 0);

    // R6 hit on eighth hop; R10 sel 3 left state 5 pointer intact
    send(8'h02, 1, st);
    send(8'h10, 0, st);
    expect_out("R6", st, 8, 3, 1, 0);
    @(negedge clk);
    check(accept_o == 0, "R4 pulse end", accept_o, 0);

    // R5 cap exceeded
    send(8'h02, 1, st);
    send(8'h20, 0, st);
    expect_out("R5", st, 8, 0, 0, 1);
    @(negedge clk);
    check(error_o == 0, "R5 pulse end", error_o, 0);

    // R8 write during a walk is ignored
    send(8'h02, 1, st);
    in_valid = 1; in_byte = 8'h21;
    @(negedge clk);
    in_valid = 0;
    check(in_ready == 0, "R8 busy", in_ready, 0);
    wr(2, 0, 0, 8'h10, 3, 0);
    while (!in_ready) @(negedge clk);
    check(error_o == 1, "R8 walk error", error_o, 1);
    send(8'h10, 1, st);
    expect_out("R8 busy write", st, 0, 0, 0, 0);

    // R8 write with a byte offered is ignored
    wr_en = 1; wr_sel = 2; wr_char = 8'h11; wr_next = 3;
    in_valid = 1; in_byte = 8'h00; sop = 1;
    @(negedge clk);
    wr_en = 0; in_valid = 0; sop = 0;
    send(8'h11, 1, st);
    expect_out("R8 offered write", st, 0, 1, 0, 0);

    // R10 idle write takes effect
    wr(2, 0, 0, 8'h12, 3, 0);
    send(8'h12, 1, st);
    expect_out("R10 root write", st, 0, 3, 1, 0);

    finish_run();
  end
endmodule